// File: doc/BRIEF.md
# Dual Store External Write Port

This block sits between a processor core and an external memory bus. A parallel-store instruction produces two stores in a single core cycle. Each store carries an address, a data word and a flag saying whether it goes to external memory. The port takes the pair in one cycle so that the core does not stall. It then sends the external stores out one at a time on a simple write bus. Each bus write takes two bus cycles: a begin phase, then a completion phase.

The first external store goes onto the bus in the same cycle the pair is accepted. With two external stores the sequence takes four bus cycles: begin first, complete first, begin second, complete second. A store aimed at internal memory never reaches this bus. The port marks it as finished in the acceptance cycle. While external work is still pending the port shows busy and refuses a new pair.

Top module: `dual_store_port`

## Requirements
- R1: After a synchronous active-high reset, `bus_we` is 0, `busy` is 0 and `req_ready` is 1.
- R2: While the port is idle, `req_ready` is 1 and a pair offered with `req_valid` is accepted in that same cycle, whichever targets the two stores have.
- R3: In the acceptance cycle, the first external store of the pair is already on the bus: `bus_we`=1, `bus_last`=0, with its address and data.
- R4: The cycle after a bus begin phase is that store's completion phase: `bus_we`=1, `bus_last`=1, with the same address and data.
- R5: When both stores are external, the second store begins in the third bus cycle and completes in the fourth. In the fifth cycle `bus_we` is 0.
- R6: When only one store is external, that store alone runs its begin and completion cycles (two cycles), and the bus is idle in the third cycle.
- R7: `int_done` bit 0 belongs to store 0 and bit 1 to store 1. In the acceptance cycle, a bit is 1 exactly when that store is internal; otherwise it is 0. An internal store never appears on the bus.
- R8: `busy` is 1 from the acceptance cycle through the last completion cycle. `req_ready` is 0 from the cycle after acceptance until that last completion cycle, and a pair offered then is ignored (no extra bus traffic).
- R9: Store 0 always goes onto the bus before store 1, whatever their addresses. `bus_src` gives the store index (0 or 1) of the bus transfer.
- R10: A reset during a sequence ends it: in the next cycle `bus_we` is 0 and the port is ready.
- R11: A new pair can be accepted in the first cycle after the last completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A store pair is offered |
| req_ready | output | 1 | Port can take a pair this cycle |
| st0_addr | input | ADDR_W | Address of store 0 |
| st0_data | input | DATA_W | Data of store 0 |
| st0_ext | input | 1 | Store 0 targets external memory |
| st1_addr | input | ADDR_W | Address of store 1 |
| st1_data | input | DATA_W | Data of store 1 |
| st1_ext | input | 1 | Store 1 targets external memory |
| int_done | output | 2 | Per-store completion flag for internal stores, acceptance cycle |
| busy | output | 1 | External work pending |
| bus_addr | output | ADDR_W | External bus address |
| bus_wdata | output | DATA_W | External bus write data |
| bus_we | output | 1 | External bus write strobe |
| bus_last | output | 1 | Completion phase of the current bus write |
| bus_src | output | 1 | Which store of the pair is on the bus |

## Verification
The bus begin phase and `int_done` are due in the acceptance cycle itself. The completion phase is due one cycle later. With two external stores, the second store is due two and three cycles after acceptance, and the idle bus with `req_ready` back at 1 is due four cycles after acceptance. The bench drives inputs one time unit after a rising edge and samples outputs mid-cycle, so each check reads the cycle whose number it names. A pair offered during the busy window is held at the inputs throughout. The bench then checks that no further bus traffic follows the last completion.

// File: rtl/dsport_pkg.sv
package dsport_pkg;

    parameter int DEF_ADDR_W = 16;
    parameter int DEF_DATA_W = 32;
    localparam int NSTORE    = 2;

    typedef enum logic [1:0] {
        SQ_IDLE       = 2'd0,
        SQ_FIRST_END  = 2'd1,
        SQ_SECOND_BEG = 2'd2,
        SQ_SECOND_END = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic we;
        logic last;
        logic src;
    } bus_ctl_t;

    function automatic logic [1:0] ext_count(input logic e0, input logic e1);
        return {1'b0, e0} + {1'b0, e1};
    endfunction

endpackage

// File: rtl/dsport_capture.sv
module dsport_capture
    import dsport_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr [NSTORE],
    input  logic [DATA_W-1:0] in_data [NSTORE],
    input  logic              in_ext  [NSTORE],
    output logic [ADDR_W-1:0] lead_addr,
    output logic [DATA_W-1:0] lead_data,
    output logic              lead_src,
    output logic [ADDR_W-1:0] slot_addr [NSTORE],
    output logic [DATA_W-1:0] slot_data [NSTORE],
    output logic              slot_src  [NSTORE]
);

    logic              pick;
    logic [ADDR_W-1:0] nxt_addr [NSTORE];
    logic [DATA_W-1:0] nxt_data [NSTORE];
    logic              nxt_src  [NSTORE];

    // store 0 leads whenever it is external; otherwise store 1 is the only candidate
    assign pick      = in_ext[0] ? 1'b0 : 1'b1;
    assign lead_addr = in_addr[pick];
    assign lead_data = in_data[pick];
    assign lead_src  = pick;

    always_comb begin
        nxt_addr[0] = lead_addr;
        nxt_data[0] = lead_data;
        nxt_src[0]  = lead_src;
        nxt_addr[1] = in_addr[1];
        nxt_data[1] = in_data[1];
        nxt_src[1]  = 1'b1;
    end

    for (genvar g = 0; g < NSTORE; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_addr[g] <= '0;
                slot_data[g] <= '0;
                slot_src[g]  <= 1'b0;
            end else if (load) begin
                slot_addr[g] <= nxt_addr[g];
                slot_data[g] <= nxt_data[g];
                slot_src[g]  <= nxt_src[g];
            end
        end

        assert_slot_hold_R8: assert property (@(posedge clk) disable iff (rst)
            !load |=> $stable(slot_addr[g]) && $stable(slot_data[g]));
    end

endmodule

// File: rtl/dsport_seq.sv
module dsport_seq
    import dsport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] n_ext,
    output seq_state_e state,
    output logic       accept,
    output logic       req_ready,
    output logic       busy
);

    seq_state_e nxt;

    assign req_ready = (state == SQ_IDLE);
    assign accept    = req_valid && req_ready;
    assign busy      = (state != SQ_IDLE) || (accept && (n_ext != 2'd0));

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:       if (accept && n_ext != 2'd0) nxt = SQ_FIRST_END;
            SQ_FIRST_END:  nxt = two_q ? SQ_SECOND_BEG : SQ_IDLE;
            SQ_SECOND_BEG: nxt = SQ_SECOND_END;
            SQ_SECOND_END: nxt = SQ_IDLE;
            default:       nxt = SQ_IDLE;
        endcase
    end

    logic two_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            two_q <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) two_q <= (n_ext == 2'd2);
        end
    end

    assert_second_follows_first_R5: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_SECOND_BEG) |-> $past(state) == SQ_FIRST_END);

    assert_no_accept_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (state != SQ_IDLE) |-> !accept);

endmodule

// File: rtl/dsport_bus.sv
module dsport_bus
    import dsport_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  seq_state_e        state,
    input  logic              start_now,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    input  logic              lead_src,
    input  logic [ADDR_W-1:0] slot_addr [NSTORE],
    input  logic [DATA_W-1:0] slot_data [NSTORE],
    input  logic              slot_src  [NSTORE],
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output bus_ctl_t          ctl
);

    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        ctl       = '{we: 1'b0, last: 1'b0, src: 1'b0};
        unique case (state)
            SQ_IDLE: begin
                if (start_now) begin
                    bus_addr  = lead_addr;
                    bus_wdata = lead_data;
                    ctl       = '{we: 1'b1, last: 1'b0, src: lead_src};
                end
            end
            SQ_FIRST_END: begin
                bus_addr  = slot_addr[0];
                bus_wdata = slot_data[0];
                ctl       = '{we: 1'b1, last: 1'b1, src: slot_src[0]};
            end
            SQ_SECOND_BEG: begin
                bus_addr  = slot_addr[1];
                bus_wdata = slot_data[1];
                ctl       = '{we: 1'b1, last: 1'b0, src: slot_src[1]};
            end
            SQ_SECOND_END: begin
                bus_addr  = slot_addr[1];
                bus_wdata = slot_data[1];
                ctl       = '{we: 1'b1, last: 1'b1, src: slot_src[1]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dual_store_port.sv
module dual_store_port
    import dsport_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] st0_addr,
    input  logic [DATA_W-1:0] st0_data,
    input  logic              st0_ext,
    input  logic [ADDR_W-1:0] st1_addr,
    input  logic [DATA_W-1:0] st1_data,
    input  logic              st1_ext,
    output logic [1:0]        int_done,
    output logic              busy,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_last,
    output logic              bus_src
);

    logic [ADDR_W-1:0] in_addr [NSTORE];
    logic [DATA_W-1:0] in_data [NSTORE];
    logic              in_ext  [NSTORE];
    logic [ADDR_W-1:0] lead_addr;
    logic [DATA_W-1:0] lead_data;
    logic              lead_src;
    logic [ADDR_W-1:0] slot_addr [NSTORE];
    logic [DATA_W-1:0] slot_data [NSTORE];
    logic              slot_src  [NSTORE];
    logic [1:0]        n_ext;
    logic              accept;
    seq_state_e        state;
    bus_ctl_t          ctl;

    assign in_addr[0] = st0_addr;
    assign in_addr[1] = st1_addr;
    assign in_data[0] = st0_data;
    assign in_data[1] = st1_data;
    assign in_ext[0]  = st0_ext;
    assign in_ext[1]  = st1_ext;
    assign n_ext      = ext_count(st0_ext, st1_ext);

    // internal stores are retired in the acceptance cycle
    assign int_done = accept ? {~st1_ext, ~st0_ext} : 2'b00;

    dsport_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .n_ext     (n_ext),
        .state     (state),
        .accept    (accept),
        .req_ready (req_ready),
        .busy      (busy)
    );

    dsport_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .in_addr   (in_addr),
        .in_data   (in_data),
        .in_ext    (in_ext),
        .lead_addr (lead_addr),
        .lead_data (lead_data),
        .lead_src  (lead_src),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_src  (slot_src)
    );

    dsport_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .state     (state),
        .start_now (accept && (n_ext != 2'd0)),
        .lead_addr (lead_addr),
        .lead_data (lead_data),
        .lead_src  (lead_src),
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .slot_src  (slot_src),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctl       (ctl)
    );

    assign bus_we   = ctl.we;
    assign bus_last = ctl.last;
    assign bus_src  = ctl.src;

    assert_begin_then_end_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_last) |=> bus_we && bus_last && $stable(bus_addr) && $stable(bus_wdata));

    assert_end_not_repeated_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_last) |=> !(bus_we && bus_last));

    assert_bus_implies_busy_R8: assert property (@(posedge clk) disable iff (rst)
        bus_we |-> busy);

    assert_stall_implies_busy_R8: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> busy);

    assert_second_after_end_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !bus_last && bus_src && !req_ready) |-> $past(bus_we && bus_last && !bus_src));

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> !bus_we && req_ready);

    assert_int_only_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
        (int_done != 2'b00) |-> (req_valid && req_ready));

endmodule

// File: tb/test_dual_store_port.sv
module test_dual_store_port;

    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] st0_addr = '0;
    logic [DW-1:0] st0_data = '0;
    logic          st0_ext = 1'b0;
    logic [AW-1:0] st1_addr = '0;
    logic [DW-1:0] st1_data = '0;
    logic          st1_ext = 1'b0;
    logic [1:0]    int_done;
    logic          busy;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic          bus_we;
    logic          bus_last;
    logic          bus_src;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    dual_store_port #(.ADDR_W(AW), .DATA_W(DW)) i_dual_store_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .st0_addr(st0_addr), .st0_data(st0_data), .st0_ext(st0_ext),
        .st1_addr(st1_addr), .st1_data(st1_data), .st1_ext(st1_ext),
        .int_done(int_done), .busy(busy), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_last(bus_last), .bus_src(bus_src)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // move to 1 unit after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // mid-cycle sample of the bus
    task automatic see_bus(input string req, input logic we, input logic last,
                           input logic [AW-1:0] a, input logic [DW-1:0] d, input logic src);
        #3;
        chk(req, "bus_we", 64'(bus_we), 64'(we));
        if (we) begin
            chk(req, "bus_last", 64'(bus_last), 64'(last));
            chk(req, "bus_addr", 64'(bus_addr), 64'(a));
            chk(req, "bus_wdata", 64'(bus_wdata), 64'(d));
            chk(req, "bus_src", 64'(bus_src), 64'(src));
        end
    endtask

    task automatic offer(input logic [AW-1:0] a0, input logic [DW-1:0] d0, input logic e0,
                         input logic [AW-1:0] a1, input logic [DW-1:0] d1, input logic e1);
        st0_addr = a0; st0_data = d0; st0_ext = e0;
        st1_addr = a1; st1_data = d1; st1_ext = e1;
        req_valid = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #3;
        chk("R1", "bus_we", 64'(bus_we), 64'd0);
        chk("R1", "busy", 64'(busy), 64'd0);
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
    endtask

    task automatic t_both_ext();
        tick();
        offer(16'h0300, 32'hAAAA0001, 1'b1, 16'h0010, 32'hBBBB0002, 1'b1);
        #1;
        chk("R2", "req_ready", 64'(req_ready), 64'd1);
        chk("R7", "int_done", 64'(int_done), 64'd0);
        chk("R8", "busy acc", 64'(busy), 64'd1);
        see_bus("R3", 1'b1, 1'b0, 16'h0300, 32'hAAAA0001, 1'b0);
        tick();
        // keep offering a different pair while the port is busy
        offer(16'h0777, 32'h77777777, 1'b1, 16'h0888, 32'h88888888, 1'b1);
        #1;
        chk("R8", "req_ready c1", 64'(req_ready), 64'd0);
        chk("R7", "int_done c1", 64'(int_done), 64'd0);
        see_bus("R4", 1'b1, 1'b1, 16'h0300, 32'hAAAA0001, 1'b0);
        tick();
        see_bus("R9", 1'b1, 1'b0, 16'h0010, 32'hBBBB0002, 1'b1);
        tick();
        #1;
        chk("R8", "busy c3", 64'(busy), 64'd1);
        chk("R8", "req_ready c3", 64'(req_ready), 64'd0);
        see_bus("R5", 1'b1, 1'b1, 16'h0010, 32'hBBBB0002, 1'b1);
        tick();
        req_valid = 1'b0;
        #1;
        chk("R5", "busy c4", 64'(busy), 64'd0);
        chk("R11", "req_ready c4", 64'(req_ready), 64'd1);
        see_bus("R8", 1'b0, 1'b0, '0, '0, 1'b0);
        tick();
        see_bus("R8", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_one_ext(input logic which);
        tick();
        if (which)
            offer(16'h1111, 32'h11110000, 1'b0, 16'h2222, 32'h22220000, 1'b1);
        else
            offer(16'h3333, 32'h33330000, 1'b1, 16'h4444, 32'h44440000, 1'b0);
        #1;
        chk("R7", "int_done", 64'(int_done), which ? 64'd1 : 64'd2);
        if (which) see_bus("R6", 1'b1, 1'b0, 16'h2222, 32'h22220000, 1'b1);
        else       see_bus("R6", 1'b1, 1'b0, 16'h3333, 32'h33330000, 1'b0);
        tick();
        req_valid = 1'b0;
        if (which) see_bus("R6", 1'b1, 1'b1, 16'h2222, 32'h22220000, 1'b1);
        else       see_bus("R6", 1'b1, 1'b1, 16'h3333, 32'h33330000, 1'b0);
        tick();
        #1;
        chk("R6", "busy end", 64'(busy), 64'd0);
        chk("R6", "req_ready end", 64'(req_ready), 64'd1);
        see_bus("R6", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_no_ext();
        tick();
        offer(16'h5555, 32'h5, 1'b0, 16'h6666, 32'h6, 1'b0);
        #1;
        chk("R7", "int_done both", 64'(int_done), 64'd3);
        chk("R7", "busy", 64'(busy), 64'd0);
        see_bus("R7", 1'b0, 1'b0, '0, '0, 1'b0);
        tick();
        req_valid = 1'b0;
        #1;
        chk("R2", "req_ready", 64'(req_ready), 64'd1);
        see_bus("R7", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_mid_reset();
        tick();
        offer(16'h0A0A, 32'hA, 1'b1, 16'h0B0B, 32'hB, 1'b1);
        tick();
        req_valid = 1'b0;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        #1;
        chk("R10", "req_ready", 64'(req_ready), 64'd1);
        chk("R10", "busy", 64'(busy), 64'd0);
        see_bus("R10", 1'b0, 1'b0, '0, '0, 1'b0);
        tick();
        see_bus("R10", 1'b0, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic t_back_to_back();
        tick();
        offer(16'h00C0, 32'hC0, 1'b1, 16'h00D0, 32'hD0, 1'b0);
        tick();
        see_bus("R11", 1'b1, 1'b1, 16'h00C0, 32'hC0, 1'b0);
        tick();
        offer(16'h00E0, 32'hE0, 1'b0, 16'h00F0, 32'hF0, 1'b1);
        #1;
        chk("R11", "req_ready", 64'(req_ready), 64'd1);
        see_bus("R11", 1'b1, 1'b0, 16'h00F0, 32'hF0, 1'b1);
        tick();
        req_valid = 1'b0;
        see_bus("R11", 1'b1, 1'b1, 16'h00F0, 32'hF0, 1'b1);
        tick();
    endtask

    initial begin
        t_reset();
        t_both_ext();
        t_one_ext(1'b1);
        t_one_ext(1'b0);
        t_no_ext();
        t_mid_reset();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule